// File: doc/BRIEF.md
# Line Alarm (All-Ones) Detector

This block watches the decoded receive bit stream and raises an alarm flag when that stream is essentially all ones. Such a stream is the "blue code" that upstream equipment sends when it has lost its own signal. The block counts the zero bits seen in each measurement window. An external active-low window strobe bounds each window: a window closes on the bit in which the strobe is first seen low after having been high.

At each window close the block compares the zero count of the window just ended with a threshold (three by default). The alarm is raised only when two windows in a row, the one ending and the one before it, each held fewer zeros than the threshold. A single window at or above the threshold clears the alarm. Any other window leaves the alarm as it was. All activity is qualified by a bit-valid strobe, so the block runs correctly behind a clock-recovery stage that does not deliver a bit on every clock. The window strobe is generated elsewhere.

Top module: `ais_detect`

## Requirements
- R1: While and after the active-low reset `rst_n`, `ais_o` is 0, the zero count is empty and the window history records no short window.
- R2: A window closes only on a valid bit in which `win_n_i` is 0 and was 1 at the previous valid bit. Holding `win_n_i` low over further valid bits closes no further windows.
- R3: A zero received in the same valid bit that closes a window counts toward the window that is closing. The window's count is the sum of the zeros before that bit and the zero in it, if any.
- R4: At a window close, if the closing window and the window before it each held fewer than THRESH zeros (THRESH = 3), `ais_o` becomes 1 from the next clock on.
- R5: One short window after a window with THRESH or more zeros, or after reset, does not raise `ais_o`.
- R6: At a window close, if the closing window held THRESH or more zeros, `ais_o` becomes 0 from the next clock on.
- R7: `ais_o` changes only in the clock after a window close. Between closes it holds its value.
- R8: Clocks with `bit_vld_i` low are ignored. Their data is not counted and their `win_n_i` level is not sampled.
- R9: The zero count restarts at each window close. The valid bit after a close is the first bit of the new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decode clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld_i | input | 1 | High for one clock per decoded bit |
| bit_i | input | 1 | Decoded data bit, 0 = space, 1 = mark |
| win_n_i | input | 1 | Active-low window strobe; its fall (between valid bits) closes a window |
| ais_o | output | 1 | Alarm flag: 1 while the stream is judged all ones |

## Verification
The case hardest to reach from the ports is a window whose count reaches the threshold only through the zero in its closing bit. Two wrong designs miss it: one that assigns that bit to the next window, and one that counts only registered zeros. The stimulus first raises the alarm with two empty windows. It then sends a window with two early zeros and a zero in the closing bit, so the alarm clears only if the closing zero is counted. A companion case sends two windows with two zeros each and expects the alarm to rise, which exposes a count carried across a close. Gaps in `bit_vld_i` that carry zeros and a low strobe are placed inside a window to show that non-bit clocks are ignored.

// File: rtl/ais_pkg.sv
package ais_pkg;

   // Event handed from the zero tally to the verdict stage at each window close
   typedef struct packed {
      logic close;   // a window closes in this cycle
      logic short_w; // the closing window held fewer zeros than the threshold
   } ais_evt_t;

   localparam int unsigned AIS_DEF_THRESH  = 3;
   localparam int unsigned AIS_DEF_SET_WIN = 2;

endpackage

// File: rtl/ais_win_edge.sv
// Detects the window close: strobe seen low at a valid bit after being high at the previous one.
module ais_win_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld_i,
   input  logic win_n_i,
   output logic close_o
);

   logic win_last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          win_last_q <= 1'b0;
      else if (bit_vld_i)  win_last_q <= win_n_i;
   end

   assign close_o = bit_vld_i & win_last_q & ~win_n_i;

   // A close always leaves the sampled strobe low, so the next cycle cannot close again
   p_single_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
      close_o |=> !close_o);

   // Strobe history moves only on valid bits
   p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld_i |=> $stable(win_last_q));

endmodule

// File: rtl/ais_zero_tally.sv
// Saturating zero counter for the open window; reports whether the closing window was short.
module ais_zero_tally
   import ais_pkg::*;
#(
   parameter int unsigned THRESH = AIS_DEF_THRESH
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     bit_vld_i,
   input  logic     bit_i,
   input  logic     close_i,
   output ais_evt_t evt_o
);

   localparam int unsigned CW = $clog2(THRESH + 1);

   generate
      if (THRESH < 1) begin : g_bad_thresh
         $error("ais_zero_tally: THRESH must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          zero_now;
   logic [CW:0]   sum;

   assign zero_now = bit_vld_i & ~bit_i;
   assign sum      = {1'b0, cnt_q} + {{CW{1'b0}}, zero_now};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (close_i) begin
         cnt_q <= '0;
      end else if (zero_now && (cnt_q != CW'(THRESH))) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // The closing bit's own zero is part of the sum (closing bit belongs to the ending window)
   assign evt_o.close   = close_i;
   assign evt_o.short_w = (sum < (CW+1)'(THRESH));

   p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(THRESH));

   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      close_i |=> (cnt_q == '0));

   p_idle_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_vld_i && !close_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ais_verdict.sv
// Alarm decision with window history; SET_WIN consecutive short windows raise the alarm.
module ais_verdict
   import ais_pkg::*;
#(
   parameter int unsigned SET_WIN = AIS_DEF_SET_WIN
) (
   input  logic     clk,
   input  logic     rst_n,
   input  ais_evt_t evt_i,
   output logic     ais_o
);

   generate
      if (SET_WIN < 1 || SET_WIN > 16) begin : g_bad_set
         $error("ais_verdict: SET_WIN must be 1..16");
      end
   endgenerate

   logic all_short;

   generate
      if (SET_WIN == 1) begin : g_no_hist
         assign all_short = evt_i.short_w;
      end else begin : g_hist
         localparam int unsigned HW = SET_WIN - 1;
         logic [HW-1:0] hist_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           hist_q <= '0;
            else if (evt_i.close) begin
               if (HW == 1) hist_q <= evt_i.short_w;
               else         hist_q <= {hist_q[HW-2:0], evt_i.short_w};
            end
         end
         assign all_short = evt_i.short_w & (&hist_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ais_o <= 1'b0;
      else if (evt_i.close) begin
         if (!evt_i.short_w)            ais_o <= 1'b0;
         else if (all_short)            ais_o <= 1'b1;
      end
   end

   p_change_on_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_i.close |=> $stable(ais_o));

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.close && !evt_i.short_w) |=> !ais_o);

   p_raise_needs_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ais_o) |-> $past(evt_i.close && evt_i.short_w));

endmodule

// File: rtl/ais_detect.sv
module ais_detect
   import ais_pkg::*;
#(
   parameter int unsigned THRESH  = AIS_DEF_THRESH,
   parameter int unsigned SET_WIN = AIS_DEF_SET_WIN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld_i,
   input  logic bit_i,
   input  logic win_n_i,
   output logic ais_o
);

   logic     close;
   ais_evt_t evt;

   ais_win_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld_i (bit_vld_i),
      .win_n_i   (win_n_i),
      .close_o   (close)
   );

   ais_zero_tally #(.THRESH(THRESH)) u_tally (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld_i (bit_vld_i),
      .bit_i     (bit_i),
      .close_i   (close),
      .evt_o     (evt)
   );

   ais_verdict #(.SET_WIN(SET_WIN)) u_verdict (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt),
      .ais_o (ais_o)
   );

   // R1: no alarm in the first cycle after reset release
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !ais_o);

endmodule

// File: tb/ais_detect_bench.sv
module ais_detect_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_vld_i = 1'b0;
   logic bit_i = 1'b1;
   logic win_n_i = 1'b1;
   logic ais_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ais_detect u_ais_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld_i (bit_vld_i),
      .bit_i     (bit_i),
      .win_n_i   (win_n_i),
      .ais_o     (ais_o)
   );

   task automatic check(input string req, input logic exp);
      n_chk++;
      if (ais_o !== exp) begin
         n_bad++;
         $display("FAIL %s: ais_o=%b expected %b at %0t", req, ais_o, exp, $time);
      end
   endtask

   // one clock; inputs set at the falling edge, result readable 1 ns after the rising edge
   task automatic send(input logic vld, input logic d, input logic w);
      @(negedge clk);
      bit_vld_i = vld; bit_i = d; win_n_i = w;
      @(posedge clk);
      #1;
   endtask

   // window: six valid bits with strobe high, the first `zeros` of them zero, then the closing bit
   task automatic window(input int zeros, input logic edge_zero);
      for (int i = 0; i < 6; i++) send(1'b1, (i < zeros) ? 1'b0 : 1'b1, 1'b1);
      send(1'b1, ~edge_zero, 1'b0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      send(1'b0, 1'b1, 1'b1);
      send(1'b0, 1'b1, 1'b1);
      rst_n = 1'b1;
      send(1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 after reset", 1'b0);
   endtask

   task automatic t_raise();
      do_reset();
      window(0, 1'b0);
      check("R5 first short window", 1'b0);
      window(1, 1'b0);
      check("R4 second short window", 1'b1);
      for (int i = 0; i < 3; i++) send(1'b1, 1'b0, 1'b1);
      check("R7 held mid-window", 1'b1);
      send(1'b1, 1'b0, 1'b0);          // closes with 4 zeros
      check("R6 rich window clears", 1'b0);
      window(2, 1'b0);
      check("R5 short after rich", 1'b0);
      window(0, 1'b0);
      check("R4 two short after rich", 1'b1);
   endtask

   task automatic t_edge_bit();
      do_reset();
      window(0, 1'b0);
      window(0, 1'b0);
      check("R4 precondition", 1'b1);
      window(2, 1'b1);                 // 2 early zeros + zero on closing bit = 3
      check("R3 closing zero counted", 1'b0);
   endtask

   task automatic t_restart();
      do_reset();
      window(2, 1'b0);
      window(2, 1'b0);                 // carried count would reach 4 and clear
      check("R9 count restarts", 1'b1);
      send(1'b1, 1'b0, 1'b1);          // first bit of new window is a zero
      window(2, 1'b0);                 // 3 zeros in this window
      check("R9 bit after close is new window", 1'b0);
   endtask

   task automatic t_invalid();
      do_reset();
      window(0, 1'b0);
      window(0, 1'b0);
      check("R8 precondition", 1'b1);
      for (int i = 0; i < 5; i++) send(1'b0, 1'b0, (i == 2) ? 1'b0 : 1'b1);
      check("R8 no close from idle strobe", 1'b1);
      window(1, 1'b0);                 // only 1 valid zero
      check("R8 idle zeros not counted", 1'b1);
   endtask

   task automatic t_held_low();
      do_reset();
      window(0, 1'b0);                 // first short window
      for (int i = 0; i < 3; i++) send(1'b1, 1'b1, 1'b0);
      check("R2 held low gives no extra close", 1'b0);
      window(0, 1'b0);
      check("R2 next real close raises", 1'b1);
   endtask

   initial begin
      t_reset();
      t_raise();
      t_edge_bit();
      t_restart();
      t_invalid();
      t_held_low();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: ran=1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule